// File: doc/BRIEF.md
# Handshaking Parallel Port Controller

This block is the parallel I/O section of a small 8-bit microcontroller. A CPU reaches it through a register bus that has an address, write data, a combinational read-data return, and one-cycle read and write strobes. Behind the bus are three ports. Port A is a set of input pins that can only be read. Port B is an output-only register, and it gives a strobe to the peripheral each time it is written. Port C is bidirectional, and each of its pins has its own direction bit.

The peripheral drives one handshake line into the block, called the acknowledge/capture line. The block drives one handshake line back, called the strobe/ready line. One control register selects how these two lines behave:

- **Simple strobe:** a write to port B pulses the outgoing line, and an edge on the incoming line captures the port C pins.
- **Full-input:** the outgoing line reports that the CPU can accept another byte.
- **Full-output:** the outgoing line announces a fresh byte on port C, and the peripheral's edge acknowledges it.

An event flag records each capture or acknowledge, and it can raise an interrupt. The incoming line is asynchronous to the clock. It passes through a two-flop synchronizer, and edges are detected after the synchronizer.

Top module: `hspar_port`

## Requirements
- R1: After reset, the control register reads 0x00 and the direction register reads 0x00. The strobe line is low, `irq` is low and `pc_oe` is 0x00.
- R2: The register offsets are: port A pins 0x00 (read only), control 0x02, port C 0x03, port B 0x04, latched port C 0x05 (read only), port C direction 0x07. Writes to 0x00 and 0x05 have no effect. Reads of any other offset return 0x00. Port B reads back its last written value on 0x04 and drives it on `pb_out`.
- R3: A direction bit of 1 makes the port C pin an output and a 0 makes it an input. `pc_oe` equals the direction register. `pc_out` holds the last value written to 0x03. A read of 0x03 returns the written bit for output pins and the live `pc_in` bit for input pins.
- R4: In simple strobe mode (control bit 4 = 0), a write to port B makes the strobe line active for exactly the two clock cycles after the write edge.
- R5: Control bit 0 sets the strobe polarity in every mode. With 0 the line is active high and idles low. With 1 it is active low and idles high.
- R6: Control bit 1 selects the active edge of the incoming line: 1 for rising, 0 for falling. The opposite edge has no effect.
- R7: An active edge on the incoming line sets the event flag (control bit 7) at the third clock edge after the line changes. In simple strobe and full-input modes, the same edge copies `pc_in` into the latched register at 0x05.
- R8: A read of 0x05 clears the event flag, and a read of 0x03 does not. Control bit 7 is read only, so writing it has no effect.
- R9: `irq` is high while the event flag is set and control bit 6 is 1.
- R10: Full-input mode is control bit 4 = 1 with bit 3 = 0. Writing the control register into this mode asserts the ready line. An active edge captures the data and negates the ready line. A read of 0x05 asserts it again. Port B writes produce no pulse in either full mode.
- R11: Full-output mode is control bit 4 = 1 with bit 3 = 1. Writing the control register into this mode leaves the strobe line inactive. A write to 0x03 asserts it. An active edge negates it and sets the event flag, and leaves the latched register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| irq | output | 1 | Interrupt request |
| pa_in | input | 8 | Port A pins |
| pb_out | output | 8 | Port B pins |
| pc_in | input | 8 | Port C pin levels |
| pc_out | output | 8 | Port C output data |
| pc_oe | output | 8 | Port C output enables |
| stra | input | 1 | Incoming handshake line (asynchronous) |
| strb | output | 1 | Outgoing strobe/ready line |

## Verification
The bench sends edges of both polarities and checks that only the selected edge captures. A detector bound to the wrong edge would latch stale pins when the line returns to idle. It samples the event flag one edge before and one edge after the synchronizer latency. A design missing a sync stage, or adding one, would raise the interrupt a cycle early or late.

It reads port C without touching the latched register to confirm that the flag survives; clearing on the wrong address would lose events. It also checks these corner cases:
- The strobe width is exactly two cycles, so an off-by-one counter shows as a short or long pulse.
- A port B write in the full modes must not disturb the ready line.
- An acknowledge in full-output mode must leave the captured byte unchanged.

// File: rtl/hspar_pkg.sv
package hspar_pkg;
  // register offsets
  localparam int OFS_PA  = 0;
  localparam int OFS_CTL = 2;
  localparam int OFS_PC  = 3;
  localparam int OFS_PB  = 4;
  localparam int OFS_LAT = 5;
  localparam int OFS_DIR = 7;

  // control register bit positions
  localparam int B_FLAG = 7;
  localparam int B_IE   = 6;
  localparam int B_HS   = 4;
  localparam int B_OUT  = 3;
  localparam int B_RISE = 1;
  localparam int B_INV  = 0;

  typedef struct packed {
    logic ie;
    logic hs;
    logic out_dir;
    logic rise;
    logic inv;
  } ctl_t;
endpackage

// File: rtl/hspar_edge.sv
module hspar_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  input  logic rise_sel,
  output logic edge_hit
);
  // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], async_in};
  end

  logic now_lvl, prev_lvl;
  assign now_lvl  = chain[STAGES-1];
  assign prev_lvl = chain[STAGES];
  assign edge_hit = rise_sel ? (now_lvl & ~prev_lvl) : (~now_lvl & prev_lvl);

  // R7
  edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit && $stable(rise_sel) |=> !edge_hit);
endmodule

// File: rtl/hspar_regs.sv
module hspar_regs
  import hspar_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          wr_ctl,
  input  logic          wr_dir,
  input  logic          wr_pb,
  input  logic          wr_pc,
  input  logic          flag,
  input  logic [DW-1:0] lat,
  input  logic [DW-1:0] pa_in,
  input  logic [DW-1:0] pc_in,
  output ctl_t          ctl,
  output logic [DW-1:0] dir_q,
  output logic [DW-1:0] pb_q,
  output logic [DW-1:0] pc_q,
  output logic [DW-1:0] rdata
);
  logic [DW-2:0] ctl_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_bits <= '0;
      dir_q    <= '0;
      pb_q     <= '0;
      pc_q     <= '0;
    end else begin
      if (wr_ctl) ctl_bits <= wdata[DW-2:0];
      if (wr_dir) dir_q    <= wdata;
      if (wr_pb)  pb_q     <= wdata;
      if (wr_pc)  pc_q     <= wdata;
    end
  end

  assign ctl.ie      = ctl_bits[B_IE];
  assign ctl.hs      = ctl_bits[B_HS];
  assign ctl.out_dir = ctl_bits[B_OUT];
  assign ctl.rise    = ctl_bits[B_RISE];
  assign ctl.inv     = ctl_bits[B_INV];

  always_comb begin
    case (addr)
      AW'(OFS_PA):  rdata = pa_in;
      AW'(OFS_CTL): rdata = {flag, ctl_bits};
      AW'(OFS_PC):  rdata = (pc_q & dir_q) | (pc_in & ~dir_q);
      AW'(OFS_PB):  rdata = pb_q;
      AW'(OFS_LAT): rdata = lat;
      AW'(OFS_DIR): rdata = dir_q;
      default:      rdata = '0;
    endcase
  end
endmodule

// File: rtl/hspar_handshake.sv
module hspar_handshake #(
  parameter int DW        = 8,
  parameter int PULSE_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hs,
  input  logic          out_dir,
  input  logic          inv,
  input  logic          ctl_wr,
  input  logic          new_hs,
  input  logic          new_out,
  input  logic          pb_wr,
  input  logic          pc_wr,
  input  logic          lat_rd,
  input  logic          edge_hit,
  input  logic [DW-1:0] pc_pins,
  output logic          flag,
  output logic [DW-1:0] lat,
  output logic          strb
);
  localparam int CW = $clog2(PULSE_CYC + 1);

  logic [CW-1:0] cnt;
  logic          line;
  logic          pulse_on;

  assign pulse_on = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      line <= 1'b0;
      flag <= 1'b0;
      lat  <= '0;
    end else begin
      if (pb_wr && !hs)  cnt <= CW'(PULSE_CYC);
      else if (pulse_on) cnt <= cnt - CW'(1);

      if (ctl_wr)                         line <= new_hs & ~new_out;
      else if (hs && edge_hit)            line <= 1'b0;
      else if (hs && !out_dir && lat_rd)  line <= 1'b1;
      else if (hs && out_dir && pc_wr)    line <= 1'b1;

      if (edge_hit)    flag <= 1'b1;
      else if (lat_rd) flag <= 1'b0;

      if (edge_hit && !(hs && out_dir)) lat <= pc_pins;
    end
  end

  assign strb = (hs ? line : pulse_on) ^ inv;

  // R4
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pb_wr && !hs |=> pulse_on);
  // R7
  flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(edge_hit));
  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lat_rd && !edge_hit |=> !flag);
  // R10
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) && hs && !out_dir && !$past(ctl_wr) |-> !line);
  // R11
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line) && hs && out_dir && !$past(ctl_wr) |-> flag);
endmodule

// File: rtl/hspar_port.sv
module hspar_port
  import hspar_pkg::*;
#(
  parameter int DW          = 8,
  parameter int AW          = 4,
  parameter int SYNC_STAGES = 2,
  parameter int PULSE_CYC   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_rd,
  input  logic          bus_wr,
  output logic [DW-1:0] bus_rdata,
  output logic          irq,
  input  logic [DW-1:0] pa_in,
  output logic [DW-1:0] pb_out,
  input  logic [DW-1:0] pc_in,
  output logic [DW-1:0] pc_out,
  output logic [DW-1:0] pc_oe,
  input  logic          stra,
  output logic          strb
);
  logic wr_ctl, wr_dir, wr_pb, wr_pc, rd_lat;
  assign wr_ctl = bus_wr && (bus_addr == AW'(OFS_CTL));
  assign wr_dir = bus_wr && (bus_addr == AW'(OFS_DIR));
  assign wr_pb  = bus_wr && (bus_addr == AW'(OFS_PB));
  assign wr_pc  = bus_wr && (bus_addr == AW'(OFS_PC));
  assign rd_lat = bus_rd && (bus_addr == AW'(OFS_LAT));

  ctl_t          ctl;
  logic          flag, edge_hit;
  logic [DW-1:0] lat, dir_q, pb_q, pc_q;

  hspar_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata),
    .wr_ctl(wr_ctl), .wr_dir(wr_dir), .wr_pb(wr_pb), .wr_pc(wr_pc),
    .flag(flag), .lat(lat), .pa_in(pa_in), .pc_in(pc_in),
    .ctl(ctl), .dir_q(dir_q), .pb_q(pb_q), .pc_q(pc_q), .rdata(bus_rdata)
  );

  hspar_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .async_in(stra), .rise_sel(ctl.rise),
    .edge_hit(edge_hit)
  );

  hspar_handshake #(.DW(DW), .PULSE_CYC(PULSE_CYC)) u_hs (
    .clk(clk), .rst_n(rst_n), .hs(ctl.hs), .out_dir(ctl.out_dir),
    .inv(ctl.inv), .ctl_wr(wr_ctl), .new_hs(bus_wdata[B_HS]),
    .new_out(bus_wdata[B_OUT]), .pb_wr(wr_pb), .pc_wr(wr_pc),
    .lat_rd(rd_lat), .edge_hit(edge_hit), .pc_pins(pc_in),
    .flag(flag), .lat(lat), .strb(strb)
  );

  assign irq    = flag & ctl.ie;
  assign pb_out = pb_q;
  assign pc_out = pc_q;
  assign pc_oe  = dir_q;

  // R9
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(edge_hit) || $past(wr_ctl));
endmodule

// File: tb/hspar_port_test.sv
module hspar_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_rdata;
  logic       irq;
  logic [7:0] pa_in = '0, pb_out, pc_in = '0, pc_out, pc_oe;
  logic       stra = 1'b0;
  logic       strb;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  hspar_port uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata), .irq(irq),
    .pa_in(pa_in), .pb_out(pb_out), .pc_in(pc_in), .pc_out(pc_out),
    .pc_oe(pc_oe), .stra(stra), .strb(strb)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic stra_to(input logic v);
    stra = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R1 strb", {7'b0, strb}, 8'h00);
    check("R1 irq", {7'b0, irq}, 8'h00);
    check("R1 pc_oe", pc_oe, 8'h00);
    bus_read(4'h2, d); check("R1 ctl", d, 8'h00);
    bus_read(4'h7, d); check("R1 dir", d, 8'h00);
  endtask

  task automatic t_regmap;
    logic [7:0] d;
    bus_write(4'h2, 8'hFF);
    bus_read(4'h2, d); check("R2 ctl readback", d, 8'h7F);
    check("R5 inverted idle", {7'b0, strb}, 8'h01);
    bus_write(4'h2, 8'h00);
    bus_write(4'h7, 8'h3C);
    bus_read(4'h7, d); check("R2 dir readback", d, 8'h3C);
    bus_write(4'h4, 8'h81);
    bus_read(4'h4, d); check("R2 pb readback", d, 8'h81);
    check("R2 pb_out", pb_out, 8'h81);
    bus_read(4'h1, d); check("R2 unmapped", d, 8'h00);
    bus_read(4'h6, d); check("R2 unmapped 6", d, 8'h00);
    bus_write(4'h5, 8'hFF);
    bus_read(4'h5, d); check("R2 latched ro", d, 8'h00);
    pa_in = 8'h5A;
    bus_write(4'h0, 8'hFF);
    bus_read(4'h0, d); check("R2 port A", d, 8'h5A);
  endtask

  task automatic t_portc;
    logic [7:0] d;
    bus_write(4'h7, 8'hF0);
    bus_write(4'h3, 8'hA5);
    pc_in = 8'h3C;
    bus_read(4'h3, d); check("R3 mixed read", d, 8'hAC);
    check("R3 pc_oe", pc_oe, 8'hF0);
    check("R3 pc_out", pc_out, 8'hA5);
  endtask

  task automatic t_strobe;
    bus_write(4'h2, 8'h00);
    bus_write(4'h4, 8'h81);
    check("R4 pulse c1", {7'b0, strb}, 8'h01);
    @(negedge clk); check("R4 pulse c2", {7'b0, strb}, 8'h01);
    @(negedge clk); check("R4 pulse end", {7'b0, strb}, 8'h00);
    bus_write(4'h2, 8'h01);
    check("R5 idle high", {7'b0, strb}, 8'h01);
    bus_write(4'h4, 8'h18);
    check("R5 active low c1", {7'b0, strb}, 8'h00);
    @(negedge clk); check("R5 active low c2", {7'b0, strb}, 8'h00);
    @(negedge clk); check("R5 back idle", {7'b0, strb}, 8'h01);
  endtask

  task automatic t_capture;
    logic [7:0] d;
    bus_write(4'h2, 8'h42);
    pc_in = 8'h96;
    stra = 1'b1;
    repeat (2) @(negedge clk);
    check("R7 not yet at edge 2", {7'b0, irq}, 8'h00);
    @(negedge clk);
    check("R7 flag at edge 3", {7'b0, irq}, 8'h01);
    bus_read(4'h2, d); check("R7 flag bit", d, 8'hC2);
    pc_in = 8'h11;
    stra_to(1'b0);
    bus_read(4'h3, d); check("R3 read pins", d, 8'hA1);
    check("R8 pc read keeps flag", {7'b0, irq}, 8'h01);
    bus_read(4'h5, d); check("R6 falling ignored", d, 8'h96);
    check("R8 cleared by latched read", {7'b0, irq}, 8'h00);
    bus_read(4'h2, d); check("R8 ctl after clear", d, 8'h42);
  endtask

  task automatic t_falling;
    logic [7:0] d;
    bus_write(4'h2, 8'h40);
    stra_to(1'b1);
    check("R6 rising ignored", {7'b0, irq}, 8'h00);
    pc_in = 8'h3E;
    stra_to(1'b0);
    check("R9 irq on fall", {7'b0, irq}, 8'h01);
    bus_write(4'h2, 8'h40);
    check("R8 flag write ignored", {7'b0, irq}, 8'h01);
    bus_write(4'h2, 8'h00);
    check("R9 irq masked", {7'b0, irq}, 8'h00);
    bus_read(4'h2, d); check("R9 flag still set", d, 8'h80);
    bus_read(4'h5, d); check("R7 latched fall", d, 8'h3E);
  endtask

  task automatic t_full_in;
    logic [7:0] d;
    bus_write(4'h2, 8'h12);
    check("R10 ready on entry", {7'b0, strb}, 8'h01);
    pc_in = 8'h77;
    stra_to(1'b1);
    check("R10 ready dropped", {7'b0, strb}, 8'h00);
    bus_read(4'h2, d); check("R10 flag", d, 8'h92);
    bus_write(4'h4, 8'h55);
    check("R10 no pulse c1", {7'b0, strb}, 8'h00);
    @(negedge clk); check("R10 no pulse c2", {7'b0, strb}, 8'h00);
    bus_read(4'h5, d); check("R10 data", d, 8'h77);
    check("R10 ready back", {7'b0, strb}, 8'h01);
    stra_to(1'b0);
  endtask

  task automatic t_full_out;
    logic [7:0] d;
    bus_write(4'h2, 8'h1A);
    check("R11 idle on entry", {7'b0, strb}, 8'h00);
    bus_write(4'h3, 8'hC3);
    check("R11 strobe on write", {7'b0, strb}, 8'h01);
    check("R11 pc_out", pc_out, 8'hC3);
    pc_in = 8'h00;
    stra_to(1'b1);
    check("R11 ack releases", {7'b0, strb}, 8'h00);
    bus_read(4'h2, d); check("R11 flag", d, 8'h9A);
    bus_read(4'h5, d); check("R11 latch unchanged", d, 8'h77);
    bus_read(4'h2, d); check("R8 cleared", d, 8'h1A);
    stra_to(1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_regmap;
    t_portc;
    t_strobe;
    t_capture;
    t_falling;
    t_full_in;
    t_full_out;
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule